// File: doc/BRIEF.md
# Smart Card Contact Shutdown Sequencer

This block controls the three card-side contacts of a smart-card style interface: a reset line, a clock line and a bidirectional open-drain data line. While the card supply is good, it forwards the host's reset and clock to the card. It also arbitrates the data line in both directions, so that a low driven on either side shows up on the other side.

When the synchronous undervoltage input rises, the block powers the contacts down in a fixed order. The reset line goes first, then the clock, then the data line. Each step is spaced by a programmable gap, nominally 4 µs, which the block counts in system clock cycles. Each step disables that line's output stage and enables its pull-down. The last step also turns off the data-line pull-up.

Once started, the sequence always runs to the fully-off state. The block leaves that state only when the supply is reported good again. A busy flag marks the sequence in progress, and an off flag marks its completion.

Top module: `card_shutdown_seq`

## Requirements
- R1: While the synchronous active-high `rst` is applied, and on the cycle after it is released with `uv_i` high, the block is fully off: `pd_en_o`=3'b111, `out_en_o`=3'b000, `io_pu_en_o`=0, `off_o`=1, `busy_o`=0, all three card lines low, `host_io_o`=1. Vector bit 0 is the reset line, bit 1 the clock line and bit 2 the data line.
- R2: In the off state with `uv_i` low, the next cycle is the live state: `out_en_o`=3'b111, `pd_en_o`=3'b000, `io_pu_en_o`=1, `off_o`=0, `busy_o`=0.
- R3: In the live state, `card_rst_o` and `card_clk_o` equal `host_rst_i` and `host_clk_i` as sampled on the previous clock edge.
- R4: On the cycle after `uv_i` is sampled high in the live state, the reset line is dropped: `pd_en_o[0]`=1, `out_en_o[0]`=0, `card_rst_o`=0 and `busy_o`=1. The clock and data lines stay live.
- R5: Exactly GAP_CYC cycles after the reset line drops, the clock line drops: `pd_en_o[1]`=1, `out_en_o[1]`=0, `card_clk_o`=0. GAP_CYC is (CLK_HZ/1000)*GAP_NS/10^6, which is 200 at the defaults.
- R6: Exactly GAP_CYC cycles after the clock line drops, the data line drops and the block is off. All pull-downs are on, all stages are off, the pull-up is off, `card_io_o`=0, `off_o`=1 and `busy_o`=0.
- R7: Clearing `uv_i` while the sequence is running neither aborts nor delays it. The block reaches the off state on the same cycle as it would otherwise.
- R8: The off state persists for as long as `uv_i` stays high. Only a low `uv_i` returns the block to the live state.
- R9: With the data line idle, a low on `host_io_i` drives `card_io_o` low on the next cycle while `host_io_o` stays high. Levels are 1 = released and 0 = pulled low.
- R10: With the data line idle, a low on `card_io_i` drives `host_io_o` low on the next cycle while `card_io_o` stays high.
- R11: If both data inputs go low in the same cycle, the host side wins. Once the winning side releases, the block drives neither side low, whatever the other input does, so no low state can lock in. It returns to idle when both inputs are high.
- R12: A line's pull-down and its output stage are never enabled together. Pull-downs are only ever enabled in order: the clock pull-down implies the reset pull-down, and the data pull-down implies the clock pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset into the off state |
| uv_i | input | 1 | Card supply undervoltage flag, active high, synchronous |
| host_rst_i | input | 1 | Host-side reset level |
| host_clk_i | input | 1 | Host-side clock level |
| host_io_i | input | 1 | Host-side data level (0 = host pulls low) |
| card_io_i | input | 1 | Card-side data level (0 = card pulls low) |
| card_rst_o | output | 1 | Level driven on the card reset contact |
| card_clk_o | output | 1 | Level driven on the card clock contact |
| card_io_o | output | 1 | Level driven on the card data contact (0 = pull low) |
| host_io_o | output | 1 | Level driven on the host data line (0 = pull low) |
| out_en_o | output | 3 | Output stage enables: bit 0 reset, bit 1 clock, bit 2 data |
| pd_en_o | output | 3 | Pull-down enables, same bit order |
| io_pu_en_o | output | 1 | Card-side data pull-up enable |
| busy_o | output | 1 | Shutdown sequence in progress |
| off_o | output | 1 | All three card lines held low |

## Verification
The data line stays live through the first two steps of the shutdown, so the start of a shutdown and a host-to-card data transfer can land on the same clock edge. The bench provokes this by lowering `host_io_i` in the same cycle that raises `uv_i`. It then expects the reset line to drop while `card_io_o` goes low and `host_io_o` stays high. When the host releases the data line, both sides must return high on the following cycles without disturbing the step timing. It also forces the arbitration tie, with both data inputs falling together, and releases the two sides one at a time.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

    localparam int LINES = 3;
    localparam int L_RST = 0;
    localparam int L_CLK = 1;
    localparam int L_IO  = 2;

    typedef enum logic [1:0] {
        SQ_OFF,
        SQ_LIVE,
        SQ_DROP_RST,
        SQ_DROP_CLK
    } seq_state_e;

    typedef enum logic [1:0] {
        OWN_IDLE,
        OWN_HOST,
        OWN_CARD,
        OWN_SETTLE
    } io_own_e;

    typedef struct packed {
        seq_state_e       st;
        logic [LINES-1:0] pd;
        logic [LINES-1:0] en;
        logic             pu;
        logic             rst_lvl;
        logic             clk_lvl;
    } seq_regs_t;

endpackage

// File: rtl/gap_timer.sv
module gap_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expire_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] TOP = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          run_d, run_q;

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (load_i) begin
            cnt_d = TOP;
            run_d = 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_d = 1'b0;
            else             cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    assign expire_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/io_arbiter.sv
module io_arbiter
    import card_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic host_lvl_i,
    input  logic card_lvl_i,
    output logic card_drv_o,
    output logic host_drv_o
);
    io_own_e own_d, own_q;

    always_comb begin
        own_d = own_q;
        unique case (own_q)
            OWN_IDLE: begin
                if (!host_lvl_i)      own_d = OWN_HOST;
                else if (!card_lvl_i) own_d = OWN_CARD;
            end
            OWN_HOST:   if (host_lvl_i) own_d = OWN_SETTLE;
            OWN_CARD:   if (card_lvl_i) own_d = OWN_SETTLE;
            OWN_SETTLE: if (host_lvl_i && card_lvl_i) own_d = OWN_IDLE;
            default:    own_d = OWN_IDLE;
        endcase
        if (clear_i) own_d = OWN_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) own_q <= OWN_IDLE;
        else     own_q <= own_d;
    end

    assign card_drv_o = (own_q != OWN_HOST);
    assign host_drv_o = (own_q != OWN_CARD);

    // R11
    never_both_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(!card_drv_o && !host_drv_o));

    // R10
    host_low_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(host_drv_o) |-> !$past(card_lvl_i));

endmodule

// File: rtl/card_shutdown_seq.sv
module card_shutdown_seq
    import card_seq_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int GAP_NS = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       uv_i,
    input  logic       host_rst_i,
    input  logic       host_clk_i,
    input  logic       host_io_i,
    input  logic       card_io_i,
    output logic       card_rst_o,
    output logic       card_clk_o,
    output logic       card_io_o,
    output logic       host_io_o,
    output logic [2:0] out_en_o,
    output logic [2:0] pd_en_o,
    output logic       io_pu_en_o,
    output logic       busy_o,
    output logic       off_o
);
    localparam int GAP_RAW = (CLK_HZ / 1000) * GAP_NS / 1_000_000;
    localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;

    seq_regs_t r_d, r_q;
    logic      tmr_load;
    logic      tmr_expire;
    logic      arb_card;
    logic      arb_host;
    logic [LINES-1:0] lvl;

    gap_timer #(.CYCLES(GAP_CYC)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load_i   (tmr_load),
        .expire_o (tmr_expire)
    );

    io_arbiter u_arb (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (!r_q.en[L_IO]),
        .host_lvl_i (host_io_i),
        .card_lvl_i (card_io_i),
        .card_drv_o (arb_card),
        .host_drv_o (arb_host)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        unique case (r_q.st)
            SQ_OFF: begin
                if (!uv_i) begin
                    r_d.st = SQ_LIVE;
                    r_d.en = '1;
                    r_d.pd = '0;
                    r_d.pu = 1'b1;
                end
            end
            SQ_LIVE: begin
                if (uv_i) begin
                    r_d.st        = SQ_DROP_RST;
                    r_d.en[L_RST] = 1'b0;
                    r_d.pd[L_RST] = 1'b1;
                    tmr_load      = 1'b1;
                end
            end
            SQ_DROP_RST: begin
                if (tmr_expire) begin
                    r_d.st        = SQ_DROP_CLK;
                    r_d.en[L_CLK] = 1'b0;
                    r_d.pd[L_CLK] = 1'b1;
                    tmr_load      = 1'b1;
                end
            end
            SQ_DROP_CLK: begin
                if (tmr_expire) begin
                    r_d.st = SQ_OFF;
                    r_d.en = '0;
                    r_d.pd = '1;
                    r_d.pu = 1'b0;
                end
            end
            default: r_d.st = SQ_OFF;
        endcase
        r_d.rst_lvl = r_d.en[L_RST] & host_rst_i;
        r_d.clk_lvl = r_d.en[L_CLK] & host_clk_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st      <= SQ_OFF;
            r_q.pd      <= '1;
            r_q.en      <= '0;
            r_q.pu      <= 1'b0;
            r_q.rst_lvl <= 1'b0;
            r_q.clk_lvl <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lvl[L_RST] = r_q.rst_lvl;
    assign lvl[L_CLK] = r_q.clk_lvl;
    assign lvl[L_IO]  = arb_card;

    logic [LINES-1:0] line_out;
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign line_out[i] = r_q.en[i] & lvl[i];
    end

    assign card_rst_o = line_out[L_RST];
    assign card_clk_o = line_out[L_CLK];
    assign card_io_o  = line_out[L_IO];
    assign host_io_o  = !r_q.en[L_IO] | arb_host;
    assign out_en_o   = r_q.en;
    assign pd_en_o    = r_q.pd;
    assign io_pu_en_o = r_q.pu;
    assign busy_o     = (r_q.st == SQ_DROP_RST) || (r_q.st == SQ_DROP_CLK);
    assign off_o      = (r_q.st == SQ_OFF);

    // R12
    pd_stage_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (pd_en_o & out_en_o) == 3'b000);

    // R12
    pd_order_chk: assert property (@(posedge clk) disable iff (rst)
        (!pd_en_o[2] || pd_en_o[1]) && (!pd_en_o[1] || pd_en_o[0]));

    // R6
    off_safe_chk: assert property (@(posedge clk) disable iff (rst)
        off_o |-> (pd_en_o == 3'b111 && !io_pu_en_o && !card_io_o));

    // R4
    uv_start_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == SQ_LIVE && uv_i) |=> (pd_en_o[0] && busy_o && !card_rst_o));

    // R7
    no_abort_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || off_o));

endmodule

// File: tb/sim_card_shutdown_seq.sv
module sim_card_shutdown_seq;

    localparam int G = 4000 / 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uv_i = 1'b1;
    logic       host_rst_i = 1'b1;
    logic       host_clk_i = 1'b1;
    logic       host_io_i = 1'b1;
    logic       card_io_i = 1'b1;
    logic       card_rst_o, card_clk_o, card_io_o, host_io_o;
    logic [2:0] out_en_o, pd_en_o;
    logic       io_pu_en_o, busy_o, off_o;

    card_shutdown_seq u0 (
        .clk        (clk),
        .rst        (rst),
        .uv_i       (uv_i),
        .host_rst_i (host_rst_i),
        .host_clk_i (host_clk_i),
        .host_io_i  (host_io_i),
        .card_io_i  (card_io_i),
        .card_rst_o (card_rst_o),
        .card_clk_o (card_clk_o),
        .card_io_o  (card_io_o),
        .host_io_o  (host_io_o),
        .out_en_o   (out_en_o),
        .pd_en_o    (pd_en_o),
        .io_pu_en_o (io_pu_en_o),
        .busy_o     (busy_o),
        .off_o      (off_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          at;
        string       req;
        logic [12:0] v;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    total = 0;
    int    bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [12:0] ob(input logic off, input logic busy, input logic pu,
                                       input logic [2:0] pd, input logic [2:0] en,
                                       input logic r, input logic c, input logic cio,
                                       input logic hio);
        return {off, busy, pu, pd, en, r, c, cio, hio};
    endfunction

    localparam logic [12:0] LIVE_ALL1 = {1'b0, 1'b0, 1'b1, 3'b000, 3'b111, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam logic [12:0] OFF_VEC   = {1'b1, 1'b0, 1'b0, 3'b111, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1};

    task automatic expect_at(input int dly, input string req, input logic [12:0] v);
        item_t it;
        it.at  = cyc + dly;
        it.req = req;
        it.v   = v;
        q.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops every expectation due this cycle and compares
    always @(posedge clk) begin
        item_t it;
        logic [12:0] got;
        #5;
        got = {off_o, busy_o, io_pu_en_o, pd_en_o, out_en_o,
               card_rst_o, card_clk_o, card_io_o, host_io_o};
        while (q.size() > 0 && q[0].at <= cyc) begin
            it = q.pop_front();
            total++;
            if (it.at != cyc || got !== it.v) begin
                bad++;
                $display("FAIL %s cyc=%0d due=%0d actual=%b expected=%b",
                         it.req, cyc, it.at, got, it.v);
            end
        end
    end

    // shutdown run starting at the current negedge; host_low adds a data transfer in the same cycle
    task automatic run_down(input string req_tag, input bit host_low);
        uv_i = 1'b1;
        if (host_low) begin
            host_io_i = 1'b0;
            expect_at(1, "R4", ob(0, 1, 1, 3'b001, 3'b110, 0, 1, 0, 1));
            tick(1);
            uv_i = 1'b0;
            host_io_i = 1'b1;
            expect_at(1, "R9", ob(0, 1, 1, 3'b001, 3'b110, 0, 1, 1, 1));
            expect_at(G - 1, "R5", ob(0, 1, 1, 3'b001, 3'b110, 0, 1, 1, 1));
            expect_at(G, req_tag, ob(0, 1, 1, 3'b011, 3'b100, 0, 0, 1, 1));
            expect_at(2 * G - 1, "R12", ob(0, 1, 1, 3'b011, 3'b100, 0, 0, 1, 1));
            expect_at(2 * G, req_tag, OFF_VEC);
            expect_at(2 * G + 1, "R8", LIVE_ALL1);
            tick(2 * G + 1);
        end else begin
            expect_at(1, "R4", ob(0, 1, 1, 3'b001, 3'b110, 0, 1, 1, 1));
            expect_at(G, "R5", ob(0, 1, 1, 3'b001, 3'b110, 0, 1, 1, 1));
            expect_at(G + 1, "R5", ob(0, 1, 1, 3'b011, 3'b100, 0, 0, 1, 1));
            expect_at(2 * G, "R12", ob(0, 1, 1, 3'b011, 3'b100, 0, 0, 1, 1));
            expect_at(2 * G + 1, "R6", OFF_VEC);
            expect_at(2 * G + 4, "R8", OFF_VEC);
            tick(2 * G + 4);
        end
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        expect_at(1, "R1", OFF_VEC);
        tick(1);
        // R8: still off while uv high
        expect_at(3, "R8", OFF_VEC);
        tick(3);
        uv_i = 1'b0;
        expect_at(1, "R2", LIVE_ALL1);
        tick(1);
        // R3 pass-through
        host_rst_i = 1'b0;
        expect_at(1, "R3", ob(0, 0, 1, 3'b000, 3'b111, 0, 1, 1, 1));
        tick(1);
        host_rst_i = 1'b1;
        host_clk_i = 1'b0;
        expect_at(1, "R3", ob(0, 0, 1, 3'b000, 3'b111, 1, 0, 1, 1));
        tick(1);
        host_clk_i = 1'b1;
        expect_at(1, "R3", LIVE_ALL1);
        tick(1);
        // R9 host to card
        host_io_i = 1'b0;
        expect_at(1, "R9", ob(0, 0, 1, 3'b000, 3'b111, 1, 1, 0, 1));
        tick(1);
        host_io_i = 1'b1;
        expect_at(1, "R9", LIVE_ALL1);
        tick(2);
        // R10 card to host
        card_io_i = 1'b0;
        expect_at(1, "R10", ob(0, 0, 1, 3'b000, 3'b111, 1, 1, 1, 0));
        tick(1);
        card_io_i = 1'b1;
        expect_at(1, "R10", LIVE_ALL1);
        tick(2);
        // R11 tie, staggered release
        host_io_i = 1'b0;
        card_io_i = 1'b0;
        expect_at(1, "R11", ob(0, 0, 1, 3'b000, 3'b111, 1, 1, 0, 1));
        tick(1);
        host_io_i = 1'b1;
        expect_at(1, "R11", LIVE_ALL1);
        tick(1);
        expect_at(1, "R11", LIVE_ALL1);
        tick(1);
        card_io_i = 1'b1;
        expect_at(1, "R11", LIVE_ALL1);
        tick(1);
        host_io_i = 1'b0;
        expect_at(1, "R11", ob(0, 0, 1, 3'b000, 3'b111, 1, 1, 0, 1));
        tick(1);
        host_io_i = 1'b1;
        expect_at(1, "R11", LIVE_ALL1);
        tick(3);
        // first shutdown, supply stays low
        run_down("R6", 1'b0);
        uv_i = 1'b0;
        expect_at(1, "R8", LIVE_ALL1);
        tick(3);
        // second shutdown: uv pulse of one cycle plus a data transfer in the same cycle
        run_down("R7", 1'b1);
        tick(3);
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R7 pending=%0d expected=0", q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule